// File: doc/BRIEF.md
# Flash Erase Status Generator

This block models, on the device side, the status logic that a NOR-style flash shows while it programs or erases. It takes decoded single-cycle command pulses: sector erase with a sector index, chip erase, program with a data byte, erase suspend and reset. It keeps a mask of the sectors chosen for erase. It runs the window during which more sectors may be added. It counts internal operation pulses against a programmable failure limit. Erase and program completion is modelled as a programmable number of pulses. The cell array is reduced to one internal data byte.

A single read port serves both modes. When no operation is in progress, a read returns the internal data byte. While an operation is pending, running, suspended or failed, a read returns an 8-bit status byte. In that byte, bit 6 is the toggle flag, bit 5 is the pulse-limit failure flag and bit 3 is the erase-timer flag. All other bits read 0.

Top module: `flash_status_gen`

## Requirements
- R1: After reset the block is not busy, the sector mask is all zero, and a read returns the data byte 8'hFF.
- R2: A sector erase accepted while idle sets the mask bit of its index and makes the block busy. While the add-sector window is open, status bit 3 reads 0.
- R3: Status bit 3 reads 1 exactly WINDOW_CYCLES clock cycles after the last accepted sector erase. That moment is the start of the erase pulses.
- R4: A sector erase that arrives while the window is open adds its sector to the mask and restarts the full window.
- R5: Once erase pulses have started, every command except erase suspend is ignored until the erase ends. Reset does not end the erase, and sector erase does not change the mask.
- R6: Chip erase from idle sets every mask bit and starts erase pulses on the next cycle with no window. Status bit 3 reads 1 at once.
- R7: While the window is open or pulses run, bit 6 inverts after each status read. In the failed state, bit 6 keeps its value across reads.
- R8: If the pulse count reaches pulse_limit before the operation completes, the block stops being busy and enters a failed state in which status bit 5 reads 1. Status bit 3 also reads 1 if the failed operation was an erase. A program that needs any 0 bit of the data byte to become 1 never completes, so it always fails this way.
- R9: In the failed state all commands except reset are ignored. Reset returns the block to array reads.
- R10: A program completes after done_pulses clock cycles and leaves the data byte equal to its old value AND the program byte. An erase completes after done_pulses counted pulses, sets the data byte to all ones and clears the mask.
- R11: Erase suspend during erase pulses freezes the pulse count, keeps the block busy and leaves bit 6 fixed on reads. A second suspend pulse resumes counting, so completion is delayed by the suspended cycles.
- R12: While idle, a read returns the data byte and does not change the toggle flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_sector_erase | input | 1 | Sector erase command pulse |
| cmd_chip_erase | input | 1 | Chip erase command pulse |
| cmd_program | input | 1 | Program command pulse |
| cmd_suspend | input | 1 | Erase suspend / resume pulse |
| cmd_reset | input | 1 | Reset command pulse |
| sector_idx | input | SECT_W | Sector index for sector erase |
| prog_data | input | DATA_W | Byte to program |
| done_pulses | input | PULSE_W | Pulses needed to finish an operation |
| pulse_limit | input | PULSE_W | Pulse count at which an operation fails |
| rd_strobe | input | 1 | Read request for this cycle |
| rd_data | output | DATA_W | Data byte when idle, status byte otherwise |
| busy | output | 1 | Window open, erase running or suspended, or program running |
| sector_mask | output | NUM_SECTORS | Sectors selected for erase |

## Verification
A wrong window counter shows up at the read port as bit 3 rising one or more cycles early or late relative to the last sector erase. A read placed in the final open-window cycle, and another one cycle later, catch such an error within a single read. A corrupted pulse counter or a lost suspend freeze moves the cycle in which busy falls, and a bench that counts cycles exactly from the accepting edge sees this on that cycle. A failure flag or mode that does not hold shows at once on the next status read, as a changed bit 5, bit 6 or array data in place of status.

// File: rtl/fes_pkg.sv
package fes_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_WINDOW = 3'd1,
      ST_ERASE  = 3'd2,
      ST_SUSP   = 3'd3,
      ST_PROG   = 3'd4,
      ST_FAIL   = 3'd5
   } fes_state_e;

   localparam int TOG_BIT  = 6;
   localparam int FAIL_BIT = 5;
   localparam int TMR_BIT  = 3;
   localparam int MIN_DATA_W = 8;

endpackage

// File: rtl/fes_window_timer.sv
module fes_window_timer #(
   parameter int WINDOW_CYCLES = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic expired
);
   localparam int CW = $clog2(WINDOW_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   assign expired = run && !restart && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || !run || expired) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/fes_pulse_counter.sv
module fes_pulse_counter #(
   parameter int PULSE_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               count_en,
   input  logic               achievable,
   input  logic [PULSE_W-1:0] done_pulses,
   input  logic [PULSE_W-1:0] pulse_limit,
   output logic               done,
   output logic               fail
);
   localparam int CW = PULSE_W + 1;

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_next;

   assign cnt_next = cnt_q + 1'b1;
   assign done = count_en && achievable && (cnt_next >= CW'(done_pulses));
   assign fail = count_en && !done && (cnt_next >= CW'(pulse_limit));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (count_en) begin
         cnt_q <= cnt_next;
      end
   end
endmodule

// File: rtl/fes_status_port.sv
module fes_status_port
   import fes_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_strobe,
   input  logic              toggle_ok,
   input  logic              show_status,
   input  logic              fail_flag,
   input  logic              tmr_flag,
   input  logic [DATA_W-1:0] array_q,
   output logic [DATA_W-1:0] rd_data,
   output logic              tog_o
);
   logic tog_q;
   logic [DATA_W-1:0] status_w;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tog_q <= 1'b0;
      end else if (rd_strobe && toggle_ok) begin
         tog_q <= ~tog_q;
      end
   end

   always_comb begin
      status_w           = '0;
      status_w[TOG_BIT]  = tog_q;
      status_w[FAIL_BIT] = fail_flag;
      status_w[TMR_BIT]  = tmr_flag;
   end

   assign rd_data = show_status ? status_w : array_q;
   assign tog_o   = tog_q;
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
   import fes_pkg::*;
#(
   parameter int NUM_SECTORS   = 8,
   parameter int WINDOW_CYCLES = 400,
   parameter int PULSE_W       = 12,
   parameter int DATA_W        = 8,
   parameter int SECT_W        = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_sector_erase,
   input  logic                   cmd_chip_erase,
   input  logic                   cmd_program,
   input  logic                   cmd_suspend,
   input  logic                   cmd_reset,
   input  logic [SECT_W-1:0]      sector_idx,
   input  logic [DATA_W-1:0]      prog_data,
   input  logic [PULSE_W-1:0]     done_pulses,
   input  logic [PULSE_W-1:0]     pulse_limit,
   input  logic                   rd_strobe,
   output logic [DATA_W-1:0]      rd_data,
   output logic                   busy,
   output logic [NUM_SECTORS-1:0] sector_mask
);
   generate
      if (NUM_SECTORS < 1) begin : g_bad_sectors
         $error("flash_status_gen: NUM_SECTORS must be at least 1");
      end
      if (WINDOW_CYCLES < 2) begin : g_bad_window
         $error("flash_status_gen: WINDOW_CYCLES must be at least 2");
      end
      if (DATA_W < MIN_DATA_W) begin : g_bad_data
         $error("flash_status_gen: DATA_W must hold the status byte");
      end
      if (PULSE_W < 2) begin : g_bad_pulse
         $error("flash_status_gen: PULSE_W must be at least 2");
      end
   endgenerate

   fes_state_e state_q, state_d;
   logic [DATA_W-1:0] array_q;
   logic [DATA_W-1:0] prog_q;
   logic              op_erase_q;

   logic add_sect, mask_clr, mask_all, win_restart;
   logic win_expired, pc_done, pc_fail, pc_clear, pc_en, achievable;
   logic tog_q;

   fes_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state_q == ST_WINDOW),
      .restart (win_restart),
      .expired (win_expired)
   );

   assign pc_en      = (state_q == ST_PROG) || ((state_q == ST_ERASE) && !cmd_suspend);
   assign pc_clear   = !((state_q == ST_ERASE) || (state_q == ST_SUSP) || (state_q == ST_PROG));
   assign achievable = (state_q != ST_PROG) || ((~array_q & prog_q) == '0);

   fes_pulse_counter #(.PULSE_W(PULSE_W)) u_pulse (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (pc_clear),
      .count_en    (pc_en),
      .achievable  (achievable),
      .done_pulses (done_pulses),
      .pulse_limit (pulse_limit),
      .done        (pc_done),
      .fail        (pc_fail)
   );

   always_comb begin
      state_d     = state_q;
      add_sect    = 1'b0;
      mask_clr    = 1'b0;
      mask_all    = 1'b0;
      win_restart = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (cmd_sector_erase) begin
               state_d     = ST_WINDOW;
               add_sect    = 1'b1;
               win_restart = 1'b1;
            end else if (cmd_chip_erase) begin
               state_d  = ST_ERASE;
               mask_all = 1'b1;
            end else if (cmd_program) begin
               state_d = ST_PROG;
            end
         end
         ST_WINDOW: begin
            if (cmd_reset) begin
               state_d  = ST_IDLE;
               mask_clr = 1'b1;
            end else if (cmd_sector_erase) begin
               add_sect    = 1'b1;
               win_restart = 1'b1;
            end else if (win_expired) begin
               state_d = ST_ERASE;
            end
         end
         ST_ERASE: begin
            if (cmd_suspend) begin
               state_d = ST_SUSP;
            end else if (pc_done) begin
               state_d  = ST_IDLE;
               mask_clr = 1'b1;
            end else if (pc_fail) begin
               state_d = ST_FAIL;
            end
         end
         ST_SUSP: begin
            if (cmd_suspend) state_d = ST_ERASE;
         end
         ST_PROG: begin
            if (pc_done)      state_d = ST_IDLE;
            else if (pc_fail) state_d = ST_FAIL;
         end
         ST_FAIL: begin
            if (cmd_reset) begin
               state_d  = ST_IDLE;
               mask_clr = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         op_erase_q <= 1'b0;
         prog_q     <= '1;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && state_d == ST_PROG) begin
            prog_q     <= prog_data;
            op_erase_q <= 1'b0;
         end else if (state_q == ST_IDLE && state_d != ST_IDLE) begin
            op_erase_q <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         array_q <= '1;
      end else if (pc_done && state_q == ST_PROG) begin
         array_q <= array_q & prog_q;
      end else if (pc_done && state_q == ST_ERASE && !cmd_suspend) begin
         array_q <= '1;
      end
   end

   for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_mask
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sector_mask[s] <= 1'b0;
         end else if (mask_clr) begin
            sector_mask[s] <= 1'b0;
         end else if (mask_all) begin
            sector_mask[s] <= 1'b1;
         end else if (add_sect && sector_idx == SECT_W'(s)) begin
            sector_mask[s] <= 1'b1;
         end
      end
   end

   fes_status_port #(.DATA_W(DATA_W)) u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_strobe   (rd_strobe),
      .toggle_ok   ((state_q == ST_WINDOW) || (state_q == ST_ERASE) || (state_q == ST_PROG)),
      .show_status (state_q != ST_IDLE),
      .fail_flag   (state_q == ST_FAIL),
      .tmr_flag    ((state_q == ST_ERASE) || (state_q == ST_SUSP) ||
                    ((state_q == ST_FAIL) && op_erase_q)),
      .array_q     (array_q),
      .rd_data     (rd_data),
      .tog_o       (tog_q)
   );

   assign busy = (state_q == ST_WINDOW) || (state_q == ST_ERASE) ||
                 (state_q == ST_SUSP)   || (state_q == ST_PROG);
endmodule

// File: rtl/fes_checker.sv
module fes_checker
   import fes_pkg::*;
#(
   parameter int NUM_SECTORS = 8,
   parameter int DATA_W      = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cmd_chip_erase,
   input logic                   cmd_sector_erase,
   input logic                   cmd_reset,
   input logic                   rd_strobe,
   input logic                   busy,
   input logic [DATA_W-1:0]      rd_data,
   input logic [NUM_SECTORS-1:0] sector_mask,
   input fes_state_e             state,
   input logic                   tog
);
   // R2: bit 3 low while window is open
   a_r2_timer_low: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WINDOW) |-> !rd_data[TMR_BIT]);

   // R5: mask frozen during erase pulses
   a_r5_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ERASE) |=> ($stable(sector_mask) || !busy));

   // R6: chip erase selects all sectors and shows bit 3 immediately
   a_r6_chip_all: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && cmd_chip_erase && !cmd_sector_erase)
      |=> ((&sector_mask) && rd_data[TMR_BIT]));

   // R7: toggle flips on reads while active
   a_r7_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && (state == ST_WINDOW || state == ST_ERASE || state == ST_PROG))
      |=> (tog != $past(tog)));

   // R7: toggle stable in failed state
   a_r7_fail_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FAIL) |=> $stable(tog));

   // R8: failure flag visible in failed state
   a_r8_fail_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FAIL) |-> (rd_data[FAIL_BIT] && !busy));

   // R9: only reset leaves the failed state
   a_r9_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FAIL && !cmd_reset) |=> (state == ST_FAIL));

   // R12: idle reads leave the toggle flag alone
   a_r12_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && rd_strobe) |=> $stable(tog));
endmodule

bind flash_status_gen fes_checker #(
   .NUM_SECTORS (NUM_SECTORS),
   .DATA_W      (DATA_W)
) u_fes_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .cmd_chip_erase   (cmd_chip_erase),
   .cmd_sector_erase (cmd_sector_erase),
   .cmd_reset        (cmd_reset),
   .rd_strobe        (rd_strobe),
   .busy             (busy),
   .rd_data          (rd_data),
   .sector_mask      (sector_mask),
   .state            (state_q),
   .tog              (tog_q)
);

// File: tb/flash_status_gen_bench.sv
module flash_status_gen_bench;
   localparam int NS  = 8;
   localparam int WIN = 20;
   localparam int PW  = 12;
   localparam int DW  = 8;
   localparam int SW  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_se = 0, cmd_ce = 0, cmd_pg = 0, cmd_su = 0, cmd_rs = 0;
   logic [SW-1:0] sector_idx = '0;
   logic [DW-1:0] prog_data = '0;
   logic [PW-1:0] done_pulses = 12'd5, pulse_limit = 12'd50;
   logic rd_strobe = 1'b0;
   logic [DW-1:0] rd_data;
   logic busy;
   logic [NS-1:0] sector_mask;

   int checks = 0, fails = 0;
   bit finished = 0;
   logic t_exp = 1'b0;
   logic [DW-1:0] exp_q[$];
   string tag_q[$];

   always #4 clk = ~clk;

   flash_status_gen #(.NUM_SECTORS(NS), .WINDOW_CYCLES(WIN), .PULSE_W(PW), .DATA_W(DW))
   u_flash_status_gen (
      .clk(clk), .rst_n(rst_n),
      .cmd_sector_erase(cmd_se), .cmd_chip_erase(cmd_ce), .cmd_program(cmd_pg),
      .cmd_suspend(cmd_su), .cmd_reset(cmd_rs),
      .sector_idx(sector_idx), .prog_data(prog_data),
      .done_pulses(done_pulses), .pulse_limit(pulse_limit),
      .rd_strobe(rd_strobe), .rd_data(rd_data), .busy(busy), .sector_mask(sector_mask)
   );

   // status byte: bit 6 toggle, bit 5 failure, bit 3 erase timer
   function automatic logic [DW-1:0] st(input logic tg, input logic fl, input logic tm);
      st = '0;
      st[6] = tg;
      st[5] = fl;
      st[3] = tm;
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // 0 sector erase, 1 chip erase, 2 program, 3 suspend, 4 reset
   task automatic pulse(input int which);
      case (which)
         0: cmd_se = 1'b1;
         1: cmd_ce = 1'b1;
         2: cmd_pg = 1'b1;
         3: cmd_su = 1'b1;
         default: cmd_rs = 1'b1;
      endcase
      @(negedge clk);
      cmd_se = 0; cmd_ce = 0; cmd_pg = 0; cmd_su = 0; cmd_rs = 0;
   endtask

   // driver: request a read and push the expected byte to the scoreboard
   task automatic rd(input logic [DW-1:0] exp, input bit flips, input string tag);
      rd_strobe = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      if (flips) t_exp = ~t_exp;
      @(negedge clk);
      rd_strobe = 1'b0;
   endtask

   // monitor: pop and compare in the middle of the low phase
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (rd_strobe && exp_q.size() > 0) begin
            logic [DW-1:0] e;
            string tg;
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            chk(32'(rd_data), 32'(e), tg);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      chk(32'(busy), 0, "R1 busy");
      chk(32'(sector_mask), 0, "R1 mask");
      rd(8'hFF, 0, "R1 array after reset");
      rd(8'hFF, 0, "R12 idle read");

      // successful program
      prog_data = 8'hA5; done_pulses = 5; pulse_limit = 50;
      pulse(2);
      chk(32'(busy), 1, "R10 program busy");
      rd(st(t_exp, 0, 0), 1, "R7 toggle read 1");
      rd(st(t_exp, 0, 0), 1, "R7 toggle read 2");
      tick(2);
      chk(32'(busy), 1, "R10 program not yet done");
      tick(1);
      chk(32'(busy), 0, "R10 program done");
      rd(8'hA5, 0, "R10 programmed byte");

      // program 1 over 0: fails at the limit
      prog_data = 8'hFF; done_pulses = 3; pulse_limit = 6;
      pulse(2);
      tick(5);
      chk(32'(busy), 1, "R8 still running");
      tick(1);
      chk(32'(busy), 0, "R8 stopped");
      rd(st(t_exp, 1, 0), 0, "R8 fail bit");
      rd(st(t_exp, 1, 0), 0, "R7 stable in fail");
      pulse(2);
      pulse(0);
      rd(st(t_exp, 1, 0), 0, "R9 commands ignored in fail");
      chk(32'(sector_mask), 0, "R9 mask untouched");
      pulse(4);
      rd(8'hA5, 0, "R9 reset to array");

      // sector erase with added sector and suspend
      done_pulses = 10; pulse_limit = 100;
      sector_idx = 3;
      pulse(0);
      chk(32'(sector_mask), 32'h08, "R2 mask bit");
      chk(32'(busy), 1, "R2 busy");
      rd(st(t_exp, 0, 0), 1, "R2 timer low");
      tick(9);
      sector_idx = 5;
      pulse(0);
      chk(32'(sector_mask), 32'h28, "R4 added sector");
      tick(19);
      rd(st(t_exp, 0, 0), 1, "R4 window restarted");
      rd(st(t_exp, 0, 1), 1, "R3 timer high");
      pulse(4);
      chk(32'(busy), 1, "R5 reset ignored");
      sector_idx = 0;
      pulse(0);
      chk(32'(sector_mask), 32'h28, "R5 sector erase ignored");
      pulse(3);
      rd(st(t_exp, 0, 1), 0, "R11 suspended read");
      tick(4);
      chk(32'(busy), 1, "R11 suspended busy");
      pulse(3);
      tick(6);
      chk(32'(busy), 1, "R11 completion delayed");
      tick(1);
      chk(32'(busy), 0, "R10 erase done");
      chk(32'(sector_mask), 0, "R10 mask cleared");
      rd(8'hFF, 0, "R10 erased byte");

      // chip erase
      prog_data = 8'h0F; done_pulses = 2; pulse_limit = 50;
      pulse(2);
      tick(2);
      rd(8'h0F, 0, "R10 second program");
      done_pulses = 4;
      pulse(1);
      chk(32'(sector_mask), 32'hFF, "R6 all sectors");
      rd(st(t_exp, 0, 1), 1, "R6 timer high at once");
      tick(3);
      chk(32'(busy), 0, "R6 chip erase done");
      rd(8'hFF, 0, "R6 erased byte");

      // chip erase that hits the limit
      done_pulses = 30; pulse_limit = 5;
      pulse(1);
      tick(5);
      rd(st(t_exp, 1, 1), 0, "R8 erase fail");
      pulse(4);
      rd(8'hFF, 0, "R9 reset after erase fail");

      tick(3);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule